// File: doc/BRIEF.md
# Back-EMF Phase-Locked Angle Tracker

This block recovers the electrical rotor angle and the electrical speed of a sensorless permanent-magnet drive from the two stationary-frame back-EMF estimates produced by an upstream observer. It does not take an arctangent and does not differentiate the angle to get speed. Instead it closes a tracking loop. On every sample strobe it rotates the EMF vector against the sine and cosine of its own angle estimate to form a phase error. A proportional-integral filter turns that error into a speed estimate, and that speed is added into a wrapping angle accumulator.

The angle is an unsigned binary fraction of one electrical turn, so it wraps without any extra logic. Speed is in angle LSBs per sample. The integral gain carries the sample period, so the configuration supplies the proportional gain, the integral gain and the integrator clamp limit as plain ports. Sine and cosine come from an internal quarter-wave table with symmetry folding. All outputs register once per strobe, and a valid flag marks the cycle in which they change.

Top module: `pll_angle_tracker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, angle_o and speed_o are 0 and valid_o is 0. The integrator starts at 0.
- R2: The trig lookup uses p = angle[15:8]. With A = 32767, sin(p) = sign-symmetric round-half-away(A·sin(2π·p/256)) and cos(p) = sin((p+64) mod 256). Both are built from a 65-entry quarter table.
- R3: On a strobe, err = (−ea·cos − eb·sin) >>> 15, an arithmetic shift that rounds toward minus infinity. The EMF inputs are signed 16-bit values.
- R4: On a strobe, the new angle is (old angle + new speed) mod 2^16. The new speed is the one produced by the same strobe.
- R5: On a strobe, the integrator becomes I + ki·err, clamped to the range [−lim, +lim]. lim is the unsigned int_lim_i and ki is unsigned.
- R6: On a strobe, speed = (kp·err + I_new) >>> 8, saturated to [−32768, 32767]. kp is unsigned.
- R7: valid_o is 1 exactly in the cycle after a cycle in which strobe_i was 1, and 0 otherwise.
- R8: In a cycle without strobe_i, angle_o, speed_o and the integrator keep their values whatever the EMF and gain inputs do.
- R9: Suppose the EMF is driven as ea = −M·sin φ, eb = M·cos φ, with M = 20000, φ advancing 300 LSB per sample, kp = 32 and ki = 1. Then the angle locks onto φ within 700 LSB after 1500 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | One-cycle sample strobe |
| emf_a_i | input | 16 | Alpha back-EMF estimate, signed |
| emf_b_i | input | 16 | Beta back-EMF estimate, signed |
| kp_i | input | 16 | Proportional gain, unsigned |
| ki_i | input | 16 | Integral gain including sample period, unsigned |
| int_lim_i | input | 39 | Integrator clamp magnitude, unsigned |
| angle_o | output | 16 | Electrical angle, fraction of a turn |
| speed_o | output | 16 | Electrical speed in angle LSB per sample, signed |
| valid_o | output | 1 | Outputs updated this cycle |

## Verification
The assertions check the following on every cycle:
- the valid pulse follows the strobe one-for-one;
- the outputs hold between strobes;
- each new angle equals the previous angle plus the reported speed;
- the integrator never leaves the clamp it was given;
- the sine/cosine pair stays on the unit circle within rounding.

Some behaviours only the bench scenarios can show. These are the exact phase-error and PI arithmetic over wide random sweeps of EMF, gains and limits, output saturation under extreme gains, and actual locking onto a rotating EMF vector.

// File: rtl/pll_trk_pkg.sv
package pll_trk_pkg;

  // quadrant of a full turn as seen by the trig folding
  typedef enum logic [1:0] {
    QD_RISE   = 2'd0,
    QD_PEAK   = 2'd1,
    QD_FALL   = 2'd2,
    QD_TROUGH = 2'd3
  } quad_e;

  function automatic logic signed [63:0] clamp_s64(input logic signed [63:0] v,
                                                    input logic signed [63:0] lo,
                                                    input logic signed [63:0] hi);
    if (v > hi) return hi;
    else if (v < lo) return lo;
    else return v;
  endfunction

endpackage

// File: rtl/pll_sincos.sv
module pll_sincos
  import pll_trk_pkg::*;
#(
  parameter int LUT_AW = 6,
  parameter int TRIG_W = 16
) (
  input  logic [LUT_AW+1:0]         phase_i,
  output logic signed [TRIG_W-1:0]  sin_o,
  output logic signed [TRIG_W-1:0]  cos_o
);
  localparam int QN   = 1 << LUT_AW;
  localparam int PH_W = LUT_AW + 2;
  localparam int AMP  = (1 << (TRIG_W-1)) - 1;

  logic [TRIG_W-2:0] qtab [QN+1];

  for (genvar k = 0; k <= QN; k++) begin : g_tab
    localparam real RAD = 1.5707963267948966 * real'(k) / real'(QN);
    localparam int  MAG = $rtoi($sin(RAD) * real'(AMP) + 0.5);
    assign qtab[k] = MAG[TRIG_W-2:0];
  end

  // fold a full-turn phase onto the quarter table
  function automatic logic signed [TRIG_W-1:0] fold(input logic [PH_W-1:0] ph);
    quad_e q;
    logic [LUT_AW-1:0] off;
    logic [LUT_AW:0] idx;
    logic signed [TRIG_W-1:0] mag;
    q   = quad_e'(ph[PH_W-1 -: 2]);
    off = ph[LUT_AW-1:0];
    if (q == QD_PEAK || q == QD_TROUGH) idx = (LUT_AW+1)'(QN) - {1'b0, off};
    else idx = {1'b0, off};
    mag = {1'b0, qtab[idx]};
    if (q == QD_FALL || q == QD_TROUGH) return -mag;
    else return mag;
  endfunction

  logic [PH_W-1:0] phase_c;
  assign phase_c = phase_i + PH_W'(QN);
  assign sin_o   = fold(phase_i);
  assign cos_o   = fold(phase_c);

endmodule

// File: rtl/pll_phase_det.sv
module pll_phase_det #(
  parameter int EMF_W  = 16,
  parameter int TRIG_W = 16,
  parameter int ERR_W  = EMF_W + 2
) (
  input  logic signed [EMF_W-1:0]  emf_a_i,
  input  logic signed [EMF_W-1:0]  emf_b_i,
  input  logic signed [TRIG_W-1:0] sin_i,
  input  logic signed [TRIG_W-1:0] cos_i,
  output logic signed [ERR_W-1:0]  err_o
);
  // cross product of EMF vector with the estimated direction, rescaled
  function automatic logic signed [ERR_W-1:0] phase_err(
      input logic signed [EMF_W-1:0] ea, input logic signed [EMF_W-1:0] eb,
      input logic signed [TRIG_W-1:0] s, input logic signed [TRIG_W-1:0] c);
    return ERR_W'((-(longint'(ea) * longint'(c)) - longint'(eb) * longint'(s)) >>> (TRIG_W-1));
  endfunction

  assign err_o = phase_err(emf_a_i, emf_b_i, sin_i, cos_i);

endmodule

// File: rtl/pll_pi_filter.sv
module pll_pi_filter
  import pll_trk_pkg::*;
#(
  parameter int ERR_W   = 18,
  parameter int GAIN_W  = 16,
  parameter int INT_W   = 40,
  parameter int SPD_W   = 16,
  parameter int GAIN_SH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd_i,
  input  logic signed [ERR_W-1:0]  err_i,
  input  logic [GAIN_W-1:0]        kp_i,
  input  logic [GAIN_W-1:0]        ki_i,
  input  logic [INT_W-2:0]         lim_i,
  output logic signed [SPD_W-1:0]  speed_o
);
  localparam longint SPD_HI = (64'sd1 <<< (SPD_W-1)) - 64'sd1;
  localparam longint SPD_LO = -(64'sd1 <<< (SPD_W-1));

  function automatic logic signed [INT_W-1:0] next_integ(
      input logic signed [INT_W-1:0] integ, input logic signed [ERR_W-1:0] err,
      input logic [GAIN_W-1:0] ki, input logic [INT_W-2:0] lim);
    return INT_W'(clamp_s64(longint'(integ) + longint'({1'b0, ki}) * longint'(err),
                            -longint'({1'b0, lim}), longint'({1'b0, lim})));
  endfunction

  function automatic logic signed [SPD_W-1:0] speed_of(
      input logic signed [INT_W-1:0] integ_n, input logic signed [ERR_W-1:0] err,
      input logic [GAIN_W-1:0] kp);
    return SPD_W'(clamp_s64((longint'({1'b0, kp}) * longint'(err) + longint'(integ_n)) >>> GAIN_SH,
                            SPD_LO, SPD_HI));
  endfunction

  logic signed [INT_W-1:0] integ_q;
  logic signed [INT_W-1:0] integ_nx;

  assign integ_nx = next_integ(integ_q, err_i, ki_i, lim_i);
  assign speed_o  = speed_of(integ_nx, err_i, kp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) integ_q <= '0;
    else if (upd_i) integ_q <= integ_nx;
  end

  // integrator stays inside the limit in force when it was updated
  assert_int_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> (longint'(integ_q) <= longint'({1'b0, $past(lim_i)})) &&
              (longint'(integ_q) >= -longint'({1'b0, $past(lim_i)})));

  // integrator untouched without an update
  assert_int_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(integ_q));

endmodule

// File: rtl/pll_angle_tracker.sv
module pll_angle_tracker
  import pll_trk_pkg::*;
#(
  parameter int EMF_W   = 16,
  parameter int TRIG_W  = 16,
  parameter int ANG_W   = 16,
  parameter int LUT_AW  = 6,
  parameter int SPD_W   = 16,
  parameter int GAIN_W  = 16,
  parameter int INT_W   = 40,
  parameter int GAIN_SH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     strobe_i,
  input  logic signed [EMF_W-1:0]  emf_a_i,
  input  logic signed [EMF_W-1:0]  emf_b_i,
  input  logic [GAIN_W-1:0]        kp_i,
  input  logic [GAIN_W-1:0]        ki_i,
  input  logic [INT_W-2:0]         int_lim_i,
  output logic [ANG_W-1:0]         angle_o,
  output logic signed [SPD_W-1:0]  speed_o,
  output logic                     valid_o
);
  localparam int PH_W  = LUT_AW + 2;
  localparam int ERR_W = EMF_W + 2;
  localparam longint AMP = (64'sd1 <<< (TRIG_W-1)) - 64'sd1;

  logic [ANG_W-1:0]         angle_q;
  logic signed [SPD_W-1:0]  speed_q;
  logic                     valid_q;

  logic signed [TRIG_W-1:0] sin_w;
  logic signed [TRIG_W-1:0] cos_w;
  logic signed [ERR_W-1:0]  err_w;
  logic signed [SPD_W-1:0]  speed_nx;
  logic [ANG_W-1:0]         angle_nx;

  pll_sincos #(.LUT_AW(LUT_AW), .TRIG_W(TRIG_W)) u_trig (
    .phase_i (angle_q[ANG_W-1 -: PH_W]),
    .sin_o   (sin_w),
    .cos_o   (cos_w)
  );

  pll_phase_det #(.EMF_W(EMF_W), .TRIG_W(TRIG_W), .ERR_W(ERR_W)) u_pd (
    .emf_a_i (emf_a_i),
    .emf_b_i (emf_b_i),
    .sin_i   (sin_w),
    .cos_i   (cos_w),
    .err_o   (err_w)
  );

  pll_pi_filter #(.ERR_W(ERR_W), .GAIN_W(GAIN_W), .INT_W(INT_W), .SPD_W(SPD_W),
                  .GAIN_SH(GAIN_SH)) u_pi (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_i   (strobe_i),
    .err_i   (err_w),
    .kp_i    (kp_i),
    .ki_i    (ki_i),
    .lim_i   (int_lim_i),
    .speed_o (speed_nx)
  );

  // backward-Euler integration: this sample's speed moves this sample's angle
  assign angle_nx = angle_q + ANG_W'(speed_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      angle_q <= '0;
      speed_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= strobe_i;
      if (strobe_i) begin
        angle_q <= angle_nx;
        speed_q <= speed_nx;
      end
    end
  end

  assign angle_o = angle_q;
  assign speed_o = speed_q;
  assign valid_o = valid_q;

  assert_valid_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |=> valid_o);

  assert_valid_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(strobe_i));

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> $stable(angle_o) && $stable(speed_o));

  assert_angle_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> angle_o == ANG_W'($past(angle_o) + ANG_W'(speed_o)));

  // table pair stays on the unit circle within rounding
  assert_unit_circle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((longint'(sin_w) * longint'(sin_w) + longint'(cos_w) * longint'(cos_w) - AMP * AMP) <= 2 * AMP) &&
    ((longint'(sin_w) * longint'(sin_w) + longint'(cos_w) * longint'(cos_w) - AMP * AMP) >= -2 * AMP));

endmodule

// File: tb/sim_pll_angle_tracker.sv
module sim_pll_angle_tracker;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst_n = 1'b0;
  logic               strobe = 1'b0;
  logic signed [15:0] emf_a = '0;
  logic signed [15:0] emf_b = '0;
  logic [15:0]        kp = '0;
  logic [15:0]        ki = '0;
  logic [38:0]        lim = '0;
  logic [15:0]        angle_o;
  logic signed [15:0] speed_o;
  logic               valid_o;

  pll_angle_tracker u0 (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .emf_a_i(emf_a), .emf_b_i(emf_b),
    .kp_i(kp), .ki_i(ki), .int_lim_i(lim), .angle_o(angle_o), .speed_o(speed_o),
    .valid_o(valid_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  longint m_ang = 0;
  longint m_int = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint rnd(input real v);
    if (v >= 0.0) return longint'($floor(v + 0.5));
    else return -longint'($floor(-v + 0.5));
  endfunction

  // R2: direct full-turn sine at 256 phases
  function automatic longint tsin(input longint p);
    return rnd(32767.0 * $sin(2.0 * 3.14159265358979323846 * real'(p) / 256.0));
  endfunction

  function automatic longint clampl(input longint v, input longint lo, input longint hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    strobe = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 angle in reset", longint'(angle_o), 0);
    chk("R1 speed in reset", longint'(speed_o), 0);
    chk("R1 valid in reset", longint'(valid_o), 0);
    rst_n = 1'b1;
    m_ang = 0;
    m_int = 0;
    @(negedge clk);
    chk("R1 angle after reset", longint'(angle_o), 0);
    chk("R1 valid after reset", longint'(valid_o), 0);
  endtask

  task automatic step(input longint ea, input longint eb, input longint kpv, input longint kiv,
                      input longint limv, input string tag);
    longint ph, s, c, err, sp;
    @(negedge clk);
    emf_a = 16'(ea); emf_b = 16'(eb);
    kp = 16'(kpv); ki = 16'(kiv); lim = 39'(limv);
    strobe = 1'b1;
    ph  = (m_ang >> 8) & 255;
    s   = tsin(ph);
    c   = tsin((ph + 64) & 255);
    err = (-(ea * c) - eb * s) >>> 15;                       // R3
    m_int = clampl(m_int + kiv * err, -limv, limv);          // R5
    sp  = clampl((kpv * err + m_int) >>> 8, -32768, 32767);  // R6
    m_ang = (m_ang + sp) & 65535;                            // R4
    @(negedge clk);
    strobe = 1'b0;
    chk("R7 valid after strobe", longint'(valid_o), 1);
    chk({tag, " speed"}, longint'(speed_o), sp);
    chk("R4 angle update", longint'(angle_o), m_ang);
    emf_a = 16'($urandom); emf_b = 16'($urandom);
    kp = 16'($urandom); ki = 16'($urandom);
    @(negedge clk);
    chk("R7 valid idle", longint'(valid_o), 0);
    chk("R8 angle hold", longint'(angle_o), m_ang);
    chk("R8 speed hold", longint'(speed_o), sp);
  endtask

  function automatic longint rs16();
    return longint'($signed(16'($urandom)));
  endfunction

  initial begin
    longint phi, d;
    real pr;
    do_reset();
    // R2: speed equals raw phase error, exposing the table over a random walk
    for (int i = 0; i < 600; i++) step(rs16(), rs16(), 256, 0, 0, "R2");
    // R3: random EMF and gains with a roomy integrator
    for (int i = 0; i < 500; i++)
      step(rs16(), rs16(), longint'($urandom_range(0, 600)), longint'($urandom_range(0, 50)),
           longint'(1) << 30, "R3");
    // R5: integral only, tight clamp
    for (int i = 0; i < 300; i++)
      step(rs16(), rs16(), 0, 65535, 5000, "R5");
    // R6: extreme gains drive the output into saturation
    for (int i = 0; i < 300; i++)
      step(rs16(), rs16(), 65535, longint'($urandom_range(0, 400)), (longint'(1) << 38) - 1, "R6");
    // R9: lock onto a rotating EMF vector
    do_reset();
    phi = 0;
    for (int i = 0; i < 2000; i++) begin
      phi = (phi + 300) & 65535;
      pr = 2.0 * 3.14159265358979323846 * real'(phi) / 65536.0;
      step(rnd(-20000.0 * $sin(pr)), rnd(20000.0 * $cos(pr)), 32, 1,
           (longint'(1) << 38) - 1, "R9");
      if (i >= 1500) begin
        d = (longint'(angle_o) - phi) & 65535;
        if (d >= 32768) d = d - 65536;
        if (d < 0) d = -d;
        chk("R9 lock error within 700", (d < 700) ? 1 : 0, 1);
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule